// File: doc/BRIEF.md
# Guarded Token Controller

This block runs a small, safe control net directly in hardware. Every place of the net is one flip-flop that is set while the place holds its token. Transitions move tokens between places. A transition fires when all of its source places are marked and its Boolean guard over the input vector is true. Each place lights a fixed set of output bits, and an output bit is the OR of the places mapped to it.

The net wired in by default is a two-branch batch sequence. An idle place forks into two filling branches, A and B. Each branch then has a heating stage. The two branches join into a pour stage, and the pour stage returns to idle. Because the net has no conflicts, every enabled transition fires on the same clock edge and no arbitration is needed. A combinational self-check raises a flag when a firing would put a second token into a place that is already marked, or when two firings would each put a token into the same place.

Top module: `pn_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After reset the marking holds only place 0 (idle), so `out_y` reads 7'h20.
- R2: A transition is enabled only when all of its source places are marked and its guard is true. A guard is true when every input bit in its must-be-high set is 1 and every input bit in its must-be-low set is 0. Input bit positions are: 0 start, 1 A full, 2 B full, 3 A hot, 4 B hot, 5 cup done. When no guard is true, the marking holds.
- R3: A firing takes place on one rising edge. It clears all of the transition's source places and sets all of its destination places. Places that no firing touches keep their value.
- R4: All enabled transitions fire on the same edge. The fork from idle (guard: bit 0) marks places 1 and 2 together. Heating A (guard: bit 3) and heating B (guard: bit 4) complete on one edge when both guards are true.
- R5: The join transition has no guard. Its sources are places 5 and 6, and its destination is place 7. It waits while only one of its sources is marked, and it fires on the edge after both are marked.
- R6: Output bit y[k] is 1 exactly when a place mapped to it is marked. The map is: y0 from p1; y1 from p2; y2 from p3 or p4; y3 from p7; y4 from p1 to p7; y5 from p0; y6 from p5. Place p6 drives only y4.
- R7: `err_dup` is 1 in a cycle where the enabled firings would add a token to a place that is marked and not being emptied, or would add two tokens to the same place. It stays 0 for the default net.
- R8: The pour-to-idle transition needs bit 5 = 1 and bit 0 = 0. It does not fire while start is still held.
- R9: After the pour stage the net is back in idle and can run a full second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_x | input | NX (6) | Logic inputs seen by the guards |
| out_y | output | NY (7) | Logic outputs decoded from the marking |
| err_dup | output | 1 | Self-check: a firing would double a token |

## Verification
The bench checks four corner cases.

- **Fork and concurrency.** It checks that the fork marks both branches on one edge and that the two heating stages can finish together. A design that fired only one enabled transition per edge would leave one branch behind.
- **Join.** It holds the join with one branch finished and checks that nothing moves. A design that tested any source instead of all sources would reach the pour stage early.
- **Return guard.** It keeps start asserted while the cup-done input is high and checks that the net does not return to idle. A design that ignored the must-be-low part of the guard would restart at once.
- **Reset during a run.** It resets the block partway through a cycle and checks that the marking reloads to idle rather than keeping the old tokens.

// File: rtl/pn_pkg.sv
// Package: sizes and default structure of the example net.
// Assumes a safe, live, conflict-free net; masks are indexed [transition][place/input].
package pn_pkg;
    localparam int NP = 8;   // places
    localparam int NT = 7;   // transitions
    localparam int NX = 6;   // logic inputs
    localparam int NY = 7;   // logic outputs

    // Source places per transition (t6 .. t0)
    localparam logic [NT-1:0][NP-1:0] NET_PRE = {
        8'h80,   // t6: pour   -> idle
        8'h60,   // t5: join of A-done, B-done
        8'h10,   // t4: heat B done
        8'h08,   // t3: heat A done
        8'h04,   // t2: fill B done
        8'h02,   // t1: fill A done
        8'h01    // t0: start fork
    };

    // Destination places per transition (t6 .. t0)
    localparam logic [NT-1:0][NP-1:0] NET_POST = {
        8'h01, 8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h06
    };

    // Guard: inputs that must be high (t6 .. t0)
    localparam logic [NT-1:0][NX-1:0] NET_GHI = {
        6'h20, 6'h00, 6'h10, 6'h08, 6'h04, 6'h02, 6'h01
    };

    // Guard: inputs that must be low (t6 .. t0)
    localparam logic [NT-1:0][NX-1:0] NET_GLO = {
        6'h01, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00
    };

    // Output bits driven by each place (p7 .. p0)
    localparam logic [NP-1:0][NY-1:0] NET_OMAP = {
        7'h18, 7'h10, 7'h50, 7'h14, 7'h14, 7'h12, 7'h11, 7'h20
    };

    localparam logic [NP-1:0] NET_INIT = 8'h01;
endpackage

// File: rtl/pn_guard_eval.sv
// Module: pn_guard_eval
// Computes the enable of each transition: all source places marked and the guard
// (product term of must-high and must-low inputs) true. Purely combinational.
module pn_guard_eval #(
    parameter int NP = 8,
    parameter int NT = 7,
    parameter int NX = 6,
    parameter logic [NT-1:0][NP-1:0] PRE = '0,
    parameter logic [NT-1:0][NX-1:0] GHI = '0,
    parameter logic [NT-1:0][NX-1:0] GLO = '0
) (
    input  logic [NP-1:0] mark,
    input  logic [NX-1:0] in_x,
    output logic [NT-1:0] fire
);
    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_tr
            logic tokens_ok;
            logic guard_ok;
            // One transition: token test and guard test
            always_comb begin
                tokens_ok = &(mark | ~PRE[t]);
                guard_ok  = (&(in_x | ~GHI[t])) & (&(~in_x | ~GLO[t]));
                fire[t]   = tokens_ok & guard_ok;
            end
        end
    endgenerate
endmodule

// File: rtl/pn_token_update.sv
// Module: pn_token_update
// Holds the marking register and applies all firing transitions in one edge.
// Assumes conflict-free firing sets; flags any token that would be doubled.
module pn_token_update #(
    parameter int NP = 8,
    parameter int NT = 7,
    parameter logic [NT-1:0][NP-1:0] PRE  = '0,
    parameter logic [NT-1:0][NP-1:0] POST = '0,
    parameter logic [NP-1:0]         INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] fire,
    output logic [NP-1:0] mark_q,
    output logic          err_dup
);
    logic [NP-1:0] consumed;
    logic [NP-1:0] produced;
    logic [NP-1:0] overlap;
    logic [NP-1:0] mark_d;

    // Gather places emptied and filled by this cycle's firings
    always_comb begin
        consumed = '0;
        produced = '0;
        overlap  = '0;
        for (int t = 0; t < NT; t++) begin
            if (fire[t]) begin
                overlap  = overlap | (produced & POST[t]);
                consumed = consumed | PRE[t];
                produced = produced | POST[t];
            end
        end
        mark_d  = (mark_q & ~consumed) | produced;
        err_dup = |((produced & mark_q & ~consumed) | overlap);
    end

    // Marking register with synchronous reset to the initial marking
    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= INIT;
        else        mark_q <= mark_d;
    end
endmodule

// File: rtl/pn_out_decode.sv
// Module: pn_out_decode
// Turns the marking into output bits: each output is the OR of its mapped places.
module pn_out_decode #(
    parameter int NP = 8,
    parameter int NY = 7,
    parameter logic [NP-1:0][NY-1:0] OMAP = '0
) (
    input  logic [NP-1:0] mark,
    output logic [NY-1:0] out_y
);
    // OR the output masks of all marked places
    always_comb begin
        out_y = '0;
        for (int p = 0; p < NP; p++) begin
            if (mark[p]) out_y = out_y | OMAP[p];
        end
    end
endmodule

// File: rtl/pn_ctrl.sv
// Module: pn_ctrl (top)
// Executes a fixed safe interpreted net: guard evaluation, token update, output decode.
// Assumes the net given by parameters is safe, live and free of conflicts.
module pn_ctrl #(
    parameter int NP = pn_pkg::NP,
    parameter int NT = pn_pkg::NT,
    parameter int NX = pn_pkg::NX,
    parameter int NY = pn_pkg::NY,
    parameter logic [NT-1:0][NP-1:0] PRE  = pn_pkg::NET_PRE,
    parameter logic [NT-1:0][NP-1:0] POST = pn_pkg::NET_POST,
    parameter logic [NT-1:0][NX-1:0] GHI  = pn_pkg::NET_GHI,
    parameter logic [NT-1:0][NX-1:0] GLO  = pn_pkg::NET_GLO,
    parameter logic [NP-1:0][NY-1:0] OMAP = pn_pkg::NET_OMAP,
    parameter logic [NP-1:0]         INIT = pn_pkg::NET_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NX-1:0] in_x,
    output logic [NY-1:0] out_y,
    output logic          err_dup
);
    logic [NP-1:0] mark_q;
    logic [NT-1:0] fire;

    pn_guard_eval #(.NP(NP), .NT(NT), .NX(NX), .PRE(PRE), .GHI(GHI), .GLO(GLO)) u_guard (
        .mark (mark_q),
        .in_x (in_x),
        .fire (fire)
    );

    pn_token_update #(.NP(NP), .NT(NT), .PRE(PRE), .POST(POST), .INIT(INIT)) u_tokens (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .mark_q  (mark_q),
        .err_dup (err_dup)
    );

    pn_out_decode #(.NP(NP), .NY(NY), .OMAP(OMAP)) u_out (
        .mark  (mark_q),
        .out_y (out_y)
    );
endmodule

// File: rtl/pn_ctrl_chk.sv
// Module: pn_ctrl_chk
// Property checker bound to pn_ctrl; watches the marking, the firing vector and outputs.
module pn_ctrl_chk #(
    parameter int NP = 8,
    parameter int NT = 7,
    parameter int NY = 7,
    parameter logic [NT-1:0][NP-1:0] PRE  = '0,
    parameter logic [NT-1:0][NP-1:0] POST = '0,
    parameter logic [NP-1:0]         INIT = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] mark,
    input logic [NT-1:0] fire,
    input logic [NY-1:0] out_y,
    input logic          err_dup
);
    logic [NP-1:0] cons_hit;
    logic [NP-1:0] prod_hit;

    // Per place: is some firing transition emptying or filling it
    always_comb begin
        cons_hit = '0;
        prod_hit = '0;
        for (int t = 0; t < NT; t++) begin
            if (fire[t]) begin
                cons_hit = cons_hit | PRE[t];
                prod_hit = prod_hit | POST[t];
            end
        end
    end

    assert_reset_init_R1: assert property (@(posedge clk)
        !rst_n |=> (mark == INIT));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_dup);

    assert_idle_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_y[5] == mark[0]);

    genvar t, p;
    generate
        for (t = 0; t < NT; t++) begin : g_t
            assert_enable_tokens_R2: assert property (@(posedge clk) disable iff (!rst_n)
                fire[t] |-> ((mark & PRE[t]) == PRE[t]));
        end
        for (p = 0; p < NP; p++) begin : g_p
            assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
                prod_hit[p] |=> mark[p]);
            assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (mark[p] && !cons_hit[p]) |=> mark[p]);
            assert_empty_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!mark[p] && !prod_hit[p]) |=> !mark[p]);
        end
    endgenerate
endmodule

bind pn_ctrl pn_ctrl_chk #(.NP(NP), .NT(NT), .NY(NY), .PRE(PRE), .POST(POST), .INIT(INIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mark    (mark_q),
    .fire    (fire),
    .out_y   (out_y),
    .err_dup (err_dup)
);

// File: tb/sim_pn_ctrl.sv
`timescale 1ns/1ps
// Directed bench for pn_ctrl: one task per scenario, each checks its own results.
module sim_pn_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] in_x = '0;
    logic [6:0] out_y;
    logic       err_dup;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pn_ctrl u0 (.clk(clk), .rst_n(rst_n), .in_x(in_x), .out_y(out_y), .err_dup(err_dup));

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: out_y=%h expected %h", req, got, exp);
        end
    endtask

    task automatic check_err(input string req);
        n_run++;
        if (err_dup !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: err_dup=%b expected 0", req, err_dup);
        end
    endtask

    // Apply inputs for exactly one rising edge, then sample at the following negedge
    task automatic step(input logic [5:0] x);
        @(negedge clk);
        in_x = x;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_x  = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset marking", out_y, 7'h20);
        check_err("R7 after reset");
    endtask

    task automatic t_idle_hold();
        step(6'h3E);                       // everything but start: t0 guard false
        check("R2 no start no fire", out_y, 7'h20);
        step(6'h00);
        check("R2 idle holds", out_y, 7'h20);
    endtask

    task automatic t_fork();
        check_err("R7 before fork");
        step(6'h01);
        check("R4 fork marks both fills", out_y, 7'h13);
    endtask

    task automatic t_branch_order();
        step(6'h04);                       // B full first
        check("R3 B fill to heat", out_y, 7'h15);
        step(6'h00);
        check("R3 unfired places hold", out_y, 7'h15);
        step(6'h02);                       // A full
        check("R3 A fill to heat", out_y, 7'h14);
    endtask

    task automatic t_join_wait();
        step(6'h08);                       // A hot only
        check("R5 A done, B heating", out_y, 7'h54);
        step(6'h00);
        check("R5 join waits", out_y, 7'h54);
        step(6'h00);
        check("R5 join still waits", out_y, 7'h54);
        step(6'h10);                       // B hot
        check("R5 both sources marked", out_y, 7'h50);
        check_err("R7 before join");
        step(6'h00);
        check("R5 join fires unguarded", out_y, 7'h18);
    endtask

    task automatic t_return_guard();
        step(6'h21);                       // cup done but start held
        check("R8 start held blocks return", out_y, 7'h18);
        step(6'h20);
        check("R8 return to idle", out_y, 7'h20);
    endtask

    task automatic t_second_cycle();
        step(6'h01);
        check("R9 second fork", out_y, 7'h13);
        step(6'h06);                       // both fills together
        check("R4 both fills on one edge", out_y, 7'h14);
        step(6'h18);                       // both heats together
        check("R4 both heats on one edge", out_y, 7'h50);
        step(6'h00);
        check("R9 second join", out_y, 7'h18);
        step(6'h20);
        check("R9 second return", out_y, 7'h20);
    endtask

    task automatic t_reset_midrun();
        step(6'h01);
        step(6'h02);
        check("R6 p3 and p2 outputs", out_y, 7'h16);
        do_reset();
        check("R1 reset mid-run", out_y, 7'h20);
    endtask

    initial begin
        t_reset();
        t_idle_hold();
        t_fork();
        t_branch_order();
        t_join_wait();
        t_return_guard();
        t_second_cycle();
        t_reset_midrun();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule